// File: doc/BRIEF.md
# Two-Step Converter Digital Encoder with Overlap Correction

This block is the digital back end of a two-step analog-to-digital converter whose fine quantization runs on two interleaved residue channels. On every conversion strobe it receives a 7-wide thermometer word from the coarse comparator bank. It also receives two 15-wide thermometer words, one from each fine channel. Each word is reduced to binary by counting its ones. Consecutive samples use the two residue channels in turn, so the fine result for a sample only arrives with the following strobe. The block therefore keeps the coarse decision and its channel tag for one conversion, then pairs them with the fine code from that channel.

The coarse and fine values are merged with one bit of redundancy: the result is the coarse value times eight, plus the fine value, minus four, held to the range 0 to 63. A coarse decision that is off by a small amount is then absorbed by the wider fine range. The 6-bit result and its valid flag appear two clock cycles after the strobe that delivered the fine code.

Top module: `twostep_encoder`

## Requirements
- R1: While reset (rst_n low, sampled on the clock) is applied, `code_o` is 0 and `code_vld_o` is 0.
- R2: Every thermometer word is converted by counting its ones, so any bit pattern, including words with bubbles, counts as its number of set bits.
- R3: The coarse word taken at one strobe is merged with the fine word taken at the next strobe.
- R4: `chan_i` at a strobe names the channel of that strobe's sample (0 selects `fine_a_i`, 1 selects `fine_b_i`), and the fine word used at the next strobe comes from that channel. `chan_i` alternates from one strobe to the next.
- R5: With coarse count C and fine count F, the output is 8*C + F - 4 when that lies in 0..63.
- R6: When 8*C + F is below 4, the output is 0.
- R7: When 8*C + F - 4 exceeds 63, the output is 63.
- R8: `code_vld_o` is high for exactly one cycle, two clock cycles after each strobe, except for the first strobe after reset, which has no prior coarse word and produces no output.
- R9: Between valid pulses `code_o` holds its last value.
- R10: While `strobe_i` is low, the thermometer and channel inputs are ignored and change neither the stored coarse word nor the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strobe_i | input | 1 | One conversion's inputs are present |
| chan_i | input | 1 | Residue channel of the current sample |
| coarse_i | input | 7 | Coarse thermometer word |
| fine_a_i | input | 15 | Fine thermometer word, channel 0 |
| fine_b_i | input | 15 | Fine thermometer word, channel 1 |
| code_o | output | 6 | Corrected output word |
| code_vld_o | output | 1 | Output word is new this cycle |

## Verification
The assertions assume the upstream sequencer hands samples to the residue channels in strict turn, so `chan_i` flips between consecutive strobes. They make no assumption about how the strobes are spaced. The stimulus keeps this by toggling its own channel variable on every strobe and sending random values only in idle cycles. It mixes back-to-back strobes with gaps of random length. Directed pairs at the bottom and top of the merge range exercise both clamps and the exact edges of the clamps.

// File: rtl/enc_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the two-step encoder.
// Assumes: two fine residue channels, identified by one bit.
package enc_pkg;
    // Default resolution of the coarse and fine quantizers (bits).
    localparam int unsigned CRS_BITS_DEF = 3;
    localparam int unsigned FIN_BITS_DEF = 4;

    // Residue channel identifier.
    typedef enum logic {
        CH_A = 1'b0,
        CH_B = 1'b1
    } chan_e;
endpackage

// File: rtl/therm_count.sv
`timescale 1ns/1ps
// Thermometer-to-binary converter by population count.
// Does: outputs the number of set bits of the input word.
// Assumes: nothing about bit order, so bubbles are tolerated.
module therm_count #(
    parameter int unsigned W  = 7,
    localparam int unsigned BW = $clog2(W + 1)
) (
    input  logic [W-1:0]  therm_i,
    output logic [BW-1:0] count_o
);
    // Add up every set bit of the word.
    always_comb begin
        count_o = '0;
        for (int i = 0; i < int'(W); i++) begin
            count_o = count_o + BW'(therm_i[i]);
        end
    end
endmodule

// File: rtl/coarse_hold.sv
`timescale 1ns/1ps
// Holds the coarse decision and channel tag of the last sample.
// Does: on a strobe, stores the coarse count and channel; marks itself
// primed once one sample has been stored since reset.
// Assumes: the channel flips between consecutive strobes.
module coarse_hold
    import enc_pkg::*;
#(
    parameter int unsigned CBW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           strobe_i,
    input  logic [CBW-1:0] count_i,
    input  chan_e          chan_i,
    output logic [CBW-1:0] held_count_o,
    output chan_e          held_chan_o,
    output logic           primed_o
);
    // Capture the coarse sample on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_count_o <= '0;
            held_chan_o  <= CH_A;
            primed_o     <= 1'b0;
        end else if (strobe_i) begin
            held_count_o <= count_i;
            held_chan_o  <= chan_i;
            primed_o     <= 1'b1;
        end
    end

    // R4: upstream hands samples to the channels in strict turn.
    a_r4_chan_alternates: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && primed_o) |-> (chan_i != held_chan_o));

    // R10: without a strobe the stored coarse word does not move.
    a_r10_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_i) |=> $stable(held_count_o));
endmodule

// File: rtl/merge_clamp.sv
`timescale 1ns/1ps
// Overlap merge of coarse and fine counts with range clamping.
// Does: registers clamp(C * 2^(FB-1) + F - 2^(FB-2)) into the output
// and raises the valid flag for one cycle.
// Assumes: FB >= 2; the output holds between valid inputs.
module merge_clamp #(
    parameter int unsigned CB = 3,
    parameter int unsigned FB = 4,
    localparam int unsigned CBW  = $clog2(2**CB),
    localparam int unsigned FBW  = $clog2(2**FB),
    localparam int unsigned OUTW = CB + FB - 1,
    localparam int unsigned SW   = OUTW + 2,
    localparam int unsigned SHIFT  = FB - 1,
    localparam int unsigned OFFSET = 2**(FB-2),
    localparam int unsigned MAXO   = 2**OUTW - 1,
    localparam int unsigned HI_F   = 2**(FB-1) + OFFSET
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            vld_i,
    input  logic [CBW-1:0]  coarse_i,
    input  logic [FBW:0]    fine_i,
    output logic [OUTW-1:0] code_o,
    output logic            vld_o
);
    logic [SW-1:0]   sum;
    logic [OUTW-1:0] clamped;

    // Form the overlapped sum and hold it inside the output range.
    always_comb begin
        sum = (SW'(coarse_i) << SHIFT) + SW'(fine_i);
        if (sum < SW'(OFFSET)) begin
            clamped = '0;
        end else if ((sum - SW'(OFFSET)) > SW'(MAXO)) begin
            clamped = OUTW'(MAXO);
        end else begin
            clamped = OUTW'(sum - SW'(OFFSET));
        end
    end

    // Output register, loaded only for a valid merge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_o <= '0;
            vld_o  <= 1'b0;
        end else begin
            vld_o <= vld_i;
            if (vld_i) begin
                code_o <= clamped;
            end
        end
    end

    // R6: a sum below the offset lands on zero.
    a_r6_clamp_low: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && coarse_i == '0 && fine_i < (FBW+1)'(OFFSET)) |=> (code_o == '0));

    // R7: a top coarse code with a large fine code lands on full scale.
    a_r7_clamp_high: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && coarse_i == '1 && fine_i >= (FBW+1)'(HI_F)) |=> (code_o == '1));
endmodule

// File: rtl/twostep_encoder.sv
`timescale 1ns/1ps
// Two-step converter encoder with two interleaved fine channels.
// Does: counts the coarse and both fine thermometer words, holds the
// coarse count one conversion, picks the fine count of the held sample's
// channel, and merges the two with one bit of overlap.
// Assumes: chan_i alternates between strobes; the fine word of a sample
// arrives with the strobe after its coarse word.
module twostep_encoder
    import enc_pkg::*;
#(
    parameter int unsigned CRS_BITS = CRS_BITS_DEF,
    parameter int unsigned FIN_BITS = FIN_BITS_DEF,
    localparam int unsigned CT   = 2**CRS_BITS - 1,
    localparam int unsigned FT   = 2**FIN_BITS - 1,
    localparam int unsigned CBW  = $clog2(CT + 1),
    localparam int unsigned FBW  = $clog2(FT + 1),
    localparam int unsigned OUTW = CRS_BITS + FIN_BITS - 1,
    localparam int unsigned NCH  = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            strobe_i,
    input  logic            chan_i,
    input  logic [CT-1:0]   coarse_i,
    input  logic [FT-1:0]   fine_a_i,
    input  logic [FT-1:0]   fine_b_i,
    output logic [OUTW-1:0] code_o,
    output logic            code_vld_o
);
    logic [CBW-1:0] coarse_cnt;
    logic [FT-1:0]  fine_words [NCH];
    logic [FBW-1:0] fine_cnt   [NCH];
    logic [CBW-1:0] held_cnt;
    chan_e          held_chan;
    logic           primed;
    logic           s1_vld;
    logic [CBW-1:0] s1_coarse;
    logic [FBW-1:0] s1_fine;

    assign fine_words[0] = fine_a_i;
    assign fine_words[1] = fine_b_i;

    therm_count #(.W(CT)) u_coarse_cnt (
        .therm_i (coarse_i),
        .count_o (coarse_cnt)
    );

    // One ones-counter per fine residue channel.
    for (genvar ch = 0; ch < int'(NCH); ch++) begin : g_fine
        therm_count #(.W(FT)) u_fine_cnt (
            .therm_i (fine_words[ch]),
            .count_o (fine_cnt[ch])
        );
    end

    coarse_hold #(.CBW(CBW)) u_hold (
        .clk          (clk),
        .rst_n        (rst_n),
        .strobe_i     (strobe_i),
        .count_i      (coarse_cnt),
        .chan_i       (chan_e'(chan_i)),
        .held_count_o (held_cnt),
        .held_chan_o  (held_chan),
        .primed_o     (primed)
    );

    // Align stage: pair the held coarse count with its channel's fine count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld    <= 1'b0;
            s1_coarse <= '0;
            s1_fine   <= '0;
        end else begin
            s1_vld <= strobe_i && primed;
            if (strobe_i) begin
                s1_coarse <= held_cnt;
                s1_fine   <= fine_cnt[held_chan];
            end
        end
    end

    merge_clamp #(.CB(CRS_BITS), .FB(FIN_BITS)) u_merge (
        .clk      (clk),
        .rst_n    (rst_n),
        .vld_i    (s1_vld),
        .coarse_i (s1_coarse),
        .fine_i   (s1_fine),
        .code_o   (code_o),
        .vld_o    (code_vld_o)
    );

    // R8: every output pulse traces back to a strobe two cycles earlier.
    a_r8_valid_lag: assert property (@(posedge clk) disable iff (!rst_n)
        code_vld_o |-> $past(strobe_i, 2));

    // R9: the output word only moves together with a valid pulse.
    a_r9_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        (!code_vld_o && !$past(code_vld_o) && $past(rst_n)) |-> $stable(code_o));
endmodule

// File: tb/twostep_encoder_test.sv
`timescale 1ns/1ps
module twostep_encoder_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        strobe_i;
    logic        chan_i;
    logic [6:0]  coarse_i;
    logic [14:0] fine_a_i;
    logic [14:0] fine_b_i;
    logic [5:0]  code_o;
    logic        code_vld_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    twostep_encoder uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe_i   (strobe_i),
        .chan_i     (chan_i),
        .coarse_i   (coarse_i),
        .fine_a_i   (fine_a_i),
        .fine_b_i   (fine_b_i),
        .code_o     (code_o),
        .code_vld_o (code_vld_o)
    );

    function automatic int ones(input logic [14:0] w);
        int n = 0;
        for (int i = 0; i < 15; i++) n += int'(w[i]);
        return n;
    endfunction

    function automatic logic [14:0] therm(input int n);
        return 15'((32'd1 << n) - 1);
    endfunction

    function automatic int merged(input int c, input int f);
        int v = c * 8 + f - 4;
        if (v < 0) return 0;
        if (v > 63) return 63;
        return v;
    endfunction

    function automatic string tag_of(input int c, input int f);
        if (c * 8 + f < 4) return "R6 R3 R4";
        if (c * 8 + f - 4 > 63) return "R7 R3 R4";
        return "R5 R3 R4";
    endfunction

    // Random thermometer word of width w: a clean code or, sometimes, raw bits (R2).
    function automatic logic [14:0] rnd_word(input int w);
        if ($urandom % 6 == 0) return 15'($urandom) & therm(w);
        return therm(int'($urandom % (w + 1)));
    endfunction

    // Directed coarse and fine counts, sample index i.
    function automatic int dir_c(input int i);
        case (i)
            0: return 0;  1: return 0;  2: return 0;  3: return 0;
            4: return 7;  5: return 7;  6: return 7;  7: return 3;
            8: return 4;  9: return 1;  default: return 2;
        endcase
    endfunction

    function automatic int dir_f(input int i);
        case (i)
            0: return 0;  1: return 3;  2: return 4;  3: return 5;
            4: return 15; 5: return 12; 6: return 11; 7: return 5;
            8: return 0;  9: return 15; default: return 8;
        endcase
    endfunction

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0d expected %0d", tag, got, exp);
        end
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R8 got 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int    prev_c  = 0;
        int    prev_ch = 0;
        int    next_ch = 0;
        bit    primed  = 1'b0;
        bit    ev1 = 1'b0, ev2 = 1'b0;
        int    eo1 = 0, eo2 = 0;
        string tg1 = "", tg2 = "";
        int    last_out = 0;
        int    ndir = 11;
        int    f_cnt;
        logic [14:0] cw, fa, fb;

        void'($urandom(32'd20240611));
        rst_n = 1'b0; strobe_i = 1'b0; chan_i = 1'b0;
        coarse_i = '0; fine_a_i = '0; fine_b_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", int'(code_o), 0);
        chk("R1", int'(code_vld_o), 0);
        rst_n = 1'b1;

        for (int cyc = 0; cyc < 5000; cyc++) begin
            // Outputs for the strobe driven two cycles ago (R8, R9).
            chk("R8", int'(code_vld_o), int'(ev2));
            if (ev2) chk(tg2, int'(code_o), eo2);
            else     chk("R9 R10", int'(code_o), last_out);
            last_out = int'(code_o);
            ev2 = ev1; eo2 = eo1; tg2 = tg1;

            if (cyc < ndir || ($urandom % 5) < 3) begin
                if (cyc < ndir) begin
                    cw = therm(dir_c(cyc));
                    f_cnt = (cyc > 0) ? dir_f(cyc - 1) : 0;
                    fa = (prev_ch == 0) ? therm(f_cnt) : rnd_word(15);
                    fb = (prev_ch == 1) ? therm(f_cnt) : rnd_word(15);
                end else begin
                    cw = rnd_word(7);
                    fa = rnd_word(15);
                    fb = rnd_word(15);
                end
                strobe_i = 1'b1;
                chan_i   = next_ch[0];
                coarse_i = cw[6:0];
                fine_a_i = fa;
                fine_b_i = fb;
                // R3/R4: held coarse meets the fine word of its own channel.
                f_cnt = (prev_ch == 1) ? ones(fb) : ones(fa);
                ev1 = primed;
                eo1 = merged(prev_c, f_cnt);
                tg1 = tag_of(prev_c, f_cnt);
                prev_c  = ones(cw & 15'h7f);
                prev_ch = next_ch;
                next_ch = 1 - next_ch;
                primed  = 1'b1;
            end else begin
                // R10: idle junk on every data and channel input.
                strobe_i = 1'b0;
                chan_i   = 1'($urandom);
                coarse_i = 7'($urandom);
                fine_a_i = 15'($urandom);
                fine_b_i = 15'($urandom);
                ev1 = 1'b0;
            end
            @(negedge clk);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule